// File: doc/BRIEF.md
# Vector Pattern Playback Peripheral

This peripheral holds a two-axis drawing pattern in two small memories, one for X and one for Y, and replays it as a pair of signed sample streams. A host reaches it through a two-phase bus slave port: the address and control of a transfer are registered in one cycle, and the write or read data follows in the next. Four word registers are decoded: a control word, a speed word, and one data port for each axis.

To load a pattern, the host sets the update bit and writes the points for each axis, first point first, to that axis's data port. Each write goes to the next free entry, and reading a data port returns how many entries that axis has taken. To play the pattern, the host writes the point count into the upper field of the control word and sets the run bit. The block then walks through the points at a rate set by the speed word. Each point is either held flat or ramped linearly toward the next one. A debug input bypasses the pattern and drives a circle computed inside the block.

Top module: `vecplay_top`

## Requirements
- R1: Word address 0 holds the control register and word address 1 holds the speed register. Both read back the full value last written. Control bit 0 is run, bit 1 is update and bit 2 is linear ramp.
- R2: A control write that changes the update bit from 0 to 1 zeroes both write pointers. While update is 1, a write to address 2 (X) or address 3 (Y) stores the data at that axis's pointer, then increments the pointer. A read of address 2 or 3 returns that axis's pointer, zero-extended.
- R3: While update is 0, writes to the data ports change neither the pointers nor the stored points. Clearing update leaves the stored pattern unchanged.
- R4: Once a pointer reaches the memory depth 2^PAT_AW it stays there, and further writes to that port are dropped.
- R5: The point count L is the control field in bits [DATA_W-1 : DATA_W-PAT_AW]. While running, the point index steps 0, 1, …, L-1 and then wraps to 0. When L is 0 or 1 the index stays at 0.
- R6: While running, the index advances once every S+1 clock cycles, where S is the speed register. The first clock edge after the run bit is written loads point 0 with phase 0 onto the outputs.
- R7: With the ramp bit clear, each output shows point i for the whole S+1 cycle period.
- R8: With the ramp bit set, each output at phase p (0…S) equals P[i] + ((P[n]-P[i])·p)/(S+1), divided toward zero. Here n is the next index, which wraps to 0 after the last point.
- R9: With run clear and the circle input low, both outputs are 0 one edge later.
- R10: While the circle input is high, the outputs take precedence over the pattern. They show a state that starts at (CIRCLE_AMP, 0) on the first edge and then updates each edge as x' = x - (y>>>CIRCLE_SHIFT), y' = y + (x'>>>CIRCLE_SHIFT).
- R11: A transfer is taken only when hsel is 1, htrans is 2 (non-sequential) or 3 (sequential), and the address bits above bit 1 are zero. Idle (0) and busy (1) transfers, and out-of-range addresses, change nothing.
- R12: After reset, all four registers read 0 and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsel | input | 1 | Slave select |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | Write flag in the address phase |
| haddr | input | HADDR_W | Word address |
| hwdata | input | DATA_W | Write data in the data phase |
| hrdata | output | DATA_W | Read data in the data phase |
| circle_sel | input | 1 | Debug circle select |
| x_out | output | DATA_W | Signed X sample |
| y_out | output | DATA_W | Signed Y sample |

## Verification
A write pointer that ends up in the wrong state shows directly as a wrong count on the next read of its data port. If a pointer moves when it should not, a point is placed in the wrong slot, and the playback then shows that point at the wrong index within one speed period. A phase counter or index that is off by one shifts every later sample, so the cycle-by-cycle comparison flags it on the first sample after the faulty advance. An error in the ramp arithmetic shows at the first phase that is not zero.

// File: rtl/vp_pkg.sv
// Shared definitions for the vector pattern player: register codes and control bit positions.
package vp_pkg;
    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_SPEED = 2'd1,
        REG_XPORT = 2'd2,
        REG_YPORT = 2'd3
    } vp_reg_e;

    localparam int CB_RUN    = 0;
    localparam int CB_UPDATE = 1;
    localparam int CB_RAMP   = 2;
    localparam int AXES      = 2;
endpackage

// File: rtl/vp_bus_regs.sv
// Bus slave and register file. Registers the address phase, applies write data in the
// data phase, and keeps one write pointer per axis that addresses the pattern memories.
// Assumes that a transfer is valid only when htrans[1] is set and the upper address bits are zero.
module vp_bus_regs
    import vp_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int PAT_AW  = 9,
    parameter int HADDR_W = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            hsel,
    input  logic [1:0]                      htrans,
    input  logic                            hwrite,
    input  logic [HADDR_W-1:0]              haddr,
    input  logic [DATA_W-1:0]               hwdata,
    output logic [DATA_W-1:0]               hrdata,
    output logic [DATA_W-1:0]               ctrl_q,
    output logic [DATA_W-1:0]               speed_q,
    output logic [AXES-1:0][PAT_AW:0]       wptr,
    output logic [AXES-1:0]                 pat_we,
    output logic [AXES-1:0][PAT_AW-1:0]     pat_waddr
);
    localparam int PTR_W = PAT_AW + 1;
    localparam logic [PTR_W-1:0] FULL = {1'b1, {PAT_AW{1'b0}}};

    logic    upper_zero;
    logic    ap_valid;
    logic    ap_write;
    vp_reg_e ap_reg;
    logic    wr_now;
    logic    arm;

    if (HADDR_W > 2) begin : g_hi
        assign upper_zero = (haddr[HADDR_W-1:2] == '0);
    end else begin : g_lo
        assign upper_zero = 1'b1;
    end

    // Capture the address phase of an accepted transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ap_valid <= 1'b0;
            ap_write <= 1'b0;
            ap_reg   <= REG_CTRL;
        end else begin
            ap_valid <= hsel && htrans[1] && upper_zero;
            ap_write <= hwrite;
            ap_reg   <= vp_reg_e'(haddr[1:0]);
        end
    end

    assign wr_now = ap_valid && ap_write;
    assign arm    = wr_now && (ap_reg == REG_CTRL) && hwdata[CB_UPDATE] && !ctrl_q[CB_UPDATE];

    // Control and speed registers take data in the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            speed_q <= '0;
        end else if (wr_now) begin
            if (ap_reg == REG_CTRL)  ctrl_q  <= hwdata;
            if (ap_reg == REG_SPEED) speed_q <= hwdata;
        end
    end

    for (genvar a = 0; a < AXES; a++) begin : g_port
        localparam vp_reg_e PORT = (a == 0) ? REG_XPORT : REG_YPORT;
        logic hit;
        assign hit = wr_now && (ap_reg == PORT) && ctrl_q[CB_UPDATE] && (wptr[a] < FULL);

        // Per-axis write pointer: cleared on arming, advanced on each stored point.
        always_ff @(posedge clk) begin
            if (!rst_n)   wptr[a] <= '0;
            else if (arm) wptr[a] <= '0;
            else if (hit) wptr[a] <= wptr[a] + 1'b1;
        end

        assign pat_we[a]    = hit;
        assign pat_waddr[a] = wptr[a][PAT_AW-1:0];
    end

    // Read data mux, valid during the data phase of a read.
    always_comb begin
        hrdata = '0;
        if (ap_valid && !ap_write) begin
            case (ap_reg)
                REG_CTRL:  hrdata = ctrl_q;
                REG_SPEED: hrdata = speed_q;
                REG_XPORT: hrdata = DATA_W'(wptr[0]);
                REG_YPORT: hrdata = DATA_W'(wptr[1]);
                default:   hrdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/vp_pattern_mem.sv
// One axis of pattern storage: a single write port and two asynchronous read ports,
// one for the current point and one for the next. No reset, since contents are loaded by the host.
module vp_pattern_mem #(
    parameter int DATA_W = 16,
    parameter int PAT_AW = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PAT_AW-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PAT_AW-1:0] raddr_a,
    input  logic [PAT_AW-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);
    localparam int DEPTH = 1 << PAT_AW;

    logic [DATA_W-1:0] store [DEPTH];

    // Store one point on a write strobe.
    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata_a = store[raddr_a];
    assign rdata_b = store[raddr_b];
endmodule

// File: rtl/vp_sequencer.sv
// Playback pacing: a phase counter runs 0..speed, and a point index wraps at len-1.
// Both are held at zero while run is low. Assumes that len 0 or 1 means a single point.
module vp_sequencer #(
    parameter int DATA_W = 16,
    parameter int PAT_AW = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [PAT_AW-1:0] len,
    input  logic [DATA_W-1:0] speed,
    output logic [PAT_AW-1:0] idx,
    output logic [PAT_AW-1:0] nidx,
    output logic [DATA_W-1:0] phase
);
    logic last;

    assign last = (len <= PAT_AW'(1)) || (idx >= len - PAT_AW'(1));
    assign nidx = last ? '0 : idx + 1'b1;

    // Advance the phase each cycle, and the index at the end of each period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            idx   <= '0;
            phase <= '0;
        end else if (phase >= speed) begin
            phase <= '0;
            idx   <= nidx;
        end else begin
            phase <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/vp_axis_out.sv
// Output stage for one axis. Chooses among the circle value, the held or ramped pattern
// value, and zero, then registers the result. The ramp quotient lies between the two points,
// so the 16-bit sum cannot overflow while phase <= speed.
module vp_axis_out #(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run,
    input  logic                     ramp_en,
    input  logic                     circle_sel,
    input  logic signed [DATA_W-1:0] cur,
    input  logic signed [DATA_W-1:0] nxt,
    input  logic        [DATA_W-1:0] phase,
    input  logic        [DATA_W-1:0] speed,
    input  logic signed [DATA_W-1:0] circle_val,
    output logic signed [DATA_W-1:0] val
);
    logic signed [DATA_W:0]     diff;
    logic signed [2*DATA_W+1:0] prod;
    logic signed [DATA_W+1:0]   den;
    logic signed [DATA_W-1:0]   quo;
    logic signed [DATA_W-1:0]   level;

    // Linear interpolation between the current and next point.
    always_comb begin
        diff  = {nxt[DATA_W-1], nxt} - {cur[DATA_W-1], cur};
        prod  = diff * $signed({1'b0, phase});
        den   = $signed({2'b00, speed} + {{(DATA_W+1){1'b0}}, 1'b1});
        quo   = DATA_W'(prod / den);
        level = ramp_en ? cur + quo : cur;
    end

    // Register the selected output.
    always_ff @(posedge clk) begin
        if (!rst_n)          val <= '0;
        else if (circle_sel) val <= circle_val;
        else if (run)        val <= level;
        else                 val <= '0;
    end
endmodule

// File: rtl/vp_circle.sv
// Debug circle source built from a shift-and-add rotation. It sits at (AMP, 0) while disabled
// and steps once per cycle while enabled. Assumes AMP leaves headroom for the small overshoot.
module vp_circle #(
    parameter int DATA_W = 16,
    parameter int AMP    = 24576,
    parameter int SHIFT  = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    output logic signed [DATA_W-1:0] cx,
    output logic signed [DATA_W-1:0] cy
);
    localparam logic signed [DATA_W-1:0] AMP_V = DATA_W'(AMP);

    logic signed [DATA_W-1:0] nx;
    logic signed [DATA_W-1:0] ny;

    // Next rotation step: update x first, then y from the new x.
    always_comb begin
        nx = cx - (cy >>> SHIFT);
        ny = cy + (nx >>> SHIFT);
    end

    // Hold the start point, or step the rotation.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cx <= AMP_V;
            cy <= '0;
        end else begin
            cx <= nx;
            cy <= ny;
        end
    end
endmodule

// File: rtl/vecplay_top.sv
// Top of the vector pattern player: bus registers, two pattern memories, a playback
// sequencer, a debug circle, and one output stage per axis.
module vecplay_top
    import vp_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int PAT_AW       = 9,
    parameter int HADDR_W      = 4,
    parameter int CIRCLE_AMP   = 24576,
    parameter int CIRCLE_SHIFT = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hsel,
    input  logic [1:0]               htrans,
    input  logic                     hwrite,
    input  logic [HADDR_W-1:0]       haddr,
    input  logic [DATA_W-1:0]        hwdata,
    output logic [DATA_W-1:0]        hrdata,
    input  logic                     circle_sel,
    output logic signed [DATA_W-1:0] x_out,
    output logic signed [DATA_W-1:0] y_out
);
    localparam int LEN_LSB = DATA_W - PAT_AW;

    logic [DATA_W-1:0]               ctrl_q;
    logic [DATA_W-1:0]               speed_q;
    logic [AXES-1:0][PAT_AW:0]       wptr;
    logic [AXES-1:0]                 pat_we;
    logic [AXES-1:0][PAT_AW-1:0]     pat_waddr;
    logic [PAT_AW-1:0]               idx;
    logic [PAT_AW-1:0]               nidx;
    logic [DATA_W-1:0]               phase;
    logic [AXES-1:0][DATA_W-1:0]     cur_pt;
    logic [AXES-1:0][DATA_W-1:0]     nxt_pt;
    logic [AXES-1:0][DATA_W-1:0]     circ;
    logic [AXES-1:0][DATA_W-1:0]     axis_val;

    vp_bus_regs #(.DATA_W(DATA_W), .PAT_AW(PAT_AW), .HADDR_W(HADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .htrans(htrans), .hwrite(hwrite),
        .haddr(haddr), .hwdata(hwdata), .hrdata(hrdata), .ctrl_q(ctrl_q),
        .speed_q(speed_q), .wptr(wptr), .pat_we(pat_we), .pat_waddr(pat_waddr)
    );

    vp_sequencer #(.DATA_W(DATA_W), .PAT_AW(PAT_AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(ctrl_q[CB_RUN]),
        .len(ctrl_q[DATA_W-1:LEN_LSB]), .speed(speed_q),
        .idx(idx), .nidx(nidx), .phase(phase)
    );

    vp_circle #(.DATA_W(DATA_W), .AMP(CIRCLE_AMP), .SHIFT(CIRCLE_SHIFT)) u_circ (
        .clk(clk), .rst_n(rst_n), .enable(circle_sel), .cx(circ[0]), .cy(circ[1])
    );

    for (genvar a = 0; a < AXES; a++) begin : g_axis
        vp_pattern_mem #(.DATA_W(DATA_W), .PAT_AW(PAT_AW)) u_mem (
            .clk(clk), .we(pat_we[a]), .waddr(pat_waddr[a]), .wdata(hwdata),
            .raddr_a(idx), .raddr_b(nidx), .rdata_a(cur_pt[a]), .rdata_b(nxt_pt[a])
        );

        vp_axis_out #(.DATA_W(DATA_W)) u_out (
            .clk(clk), .rst_n(rst_n), .run(ctrl_q[CB_RUN]), .ramp_en(ctrl_q[CB_RAMP]),
            .circle_sel(circle_sel), .cur(cur_pt[a]), .nxt(nxt_pt[a]), .phase(phase),
            .speed(speed_q), .circle_val(circ[a]), .val(axis_val[a])
        );
    end

    assign x_out = axis_val[0];
    assign y_out = axis_val[1];
endmodule

// File: rtl/vp_checker.sv
// Temporal checks on the player, bound to every instance of the top module.
module vp_checker #(
    parameter int DATA_W = 16,
    parameter int PAT_AW = 9
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [DATA_W-1:0]        ctrl_q,
    input logic [DATA_W-1:0]        speed_q,
    input logic [1:0][PAT_AW:0]     wptr,
    input logic [PAT_AW-1:0]        idx,
    input logic [DATA_W-1:0]        phase,
    input logic                     circle_sel,
    input logic [DATA_W-1:0]        x_out,
    input logic [DATA_W-1:0]        y_out
);
    localparam logic [PAT_AW:0] FULL = {1'b1, {PAT_AW{1'b0}}};

    AST_PTR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (wptr[0] <= FULL) && (wptr[1] <= FULL)); // R4

    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q[1]) |-> (wptr == '0)); // R2

    AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[1] |=> (ctrl_q[1] || $stable(wptr))); // R3

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[0] && !circle_sel) |=> (x_out == '0 && y_out == '0)); // R9

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[0] && phase < speed_q) |=> $stable(idx)); // R6
endmodule

bind vecplay_top vp_checker #(.DATA_W(DATA_W), .PAT_AW(PAT_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .speed_q(speed_q), .wptr(wptr),
    .idx(idx), .phase(phase), .circle_sel(circle_sel), .x_out(x_out), .y_out(y_out)
);

// File: tb/sim_vecplay_top.sv
// Self-checking bench: fills a 16-entry pattern and sweeps length, speed and ramp mode
// against an arithmetic model, then covers the circle, bus filtering and pointer limits.
module sim_vecplay_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int AW = 4;
    localparam int HW = 4;
    localparam int AMP = 24576;
    localparam int SH = 5;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hsel = 1'b0;
    logic [1:0] htrans = 2'b00;
    logic hwrite = 1'b0;
    logic [HW-1:0] haddr = '0;
    logic [DW-1:0] hwdata = '0;
    logic [DW-1:0] hrdata;
    logic circle_sel = 1'b0;
    logic signed [DW-1:0] x_out;
    logic signed [DW-1:0] y_out;

    int checks = 0;
    int fails = 0;
    int xp[DEPTH];
    int yp[DEPTH];

    vecplay_top #(.DATA_W(DW), .PAT_AW(AW), .HADDR_W(HW), .CIRCLE_AMP(AMP), .CIRCLE_SHIFT(SH)) u0 (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .htrans(htrans), .hwrite(hwrite),
        .haddr(haddr), .hwdata(hwdata), .hrdata(hrdata), .circle_sel(circle_sel),
        .x_out(x_out), .y_out(y_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(input int a, input int d, input logic [1:0] tr);
        hsel = 1'b1; htrans = tr; hwrite = 1'b1; haddr = HW'(a);
        @(posedge clk); @(negedge clk);
        hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0; hwdata = DW'(d);
        @(posedge clk); @(negedge clk);
    endtask

    task automatic bus_read(input int a, output int d);
        hsel = 1'b1; htrans = 2'b10; hwrite = 1'b0; haddr = HW'(a);
        @(posedge clk); @(negedge clk);
        hsel = 1'b0; htrans = 2'b00;
        d = int'(hrdata);
        @(posedge clk); @(negedge clk);
    endtask

    function automatic int model(input int t, input int len, input int spd,
                                 input bit ramp, input bit axis_y);
        int per = spd + 1;
        int ph = t % per;
        int l = (len <= 1) ? 1 : len;
        int i = (t / per) % l;
        int n = (i + 1 >= l) ? 0 : i + 1;
        int p = axis_y ? yp[i] : xp[i];
        int q = axis_y ? yp[n] : xp[n];
        if (!ramp) return p;
        return p + ((q - p) * ph) / per;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int rd;
        int lens[4] = '{0, 1, 5, 15};
        int spds[3] = '{0, 2, 3};
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12 x_out in reset", int'(x_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int r = 0; r < 4; r++) begin
            bus_read(r, rd);
            chk("R12 register after reset", rd, 0);
        end

        // R1 register readback
        bus_write(0, 16'hABC4, 2'b10);
        bus_read(0, rd); chk("R1 control readback", rd, 16'hABC4);
        bus_write(0, 0, 2'b10);
        bus_write(1, 16'h1234, 2'b10);
        bus_read(1, rd); chk("R1 speed readback", rd, 16'h1234);

        // R11 filtered transfers
        bus_write(1, 16'h5555, 2'b00);
        bus_write(1, 16'h6666, 2'b01);
        bus_write(5, 16'h7777, 2'b10);
        bus_read(1, rd); chk("R11 idle/busy/range ignored", rd, 16'h1234);
        bus_write(1, 16'h0002, 2'b11);
        bus_read(1, rd); chk("R11 sequential accepted", rd, 2);

        // R3 port write with update clear
        bus_write(2, 16'h1111, 2'b10);
        bus_read(2, rd); chk("R3 pointer unchanged", rd, 0);

        // R2 pattern load
        bus_write(0, 2, 2'b10);
        for (int i = 0; i < DEPTH; i++) begin
            xp[i] = -32767 + i * 4368;
            yp[i] = 32767 - i * 3000;
            bus_write(2, xp[i], 2'b10);
            if (i == 4) begin
                bus_read(2, rd); chk("R2 X pointer count", rd, 5);
            end
        end
        for (int i = 0; i < DEPTH; i++) bus_write(3, yp[i], 2'b10);
        bus_read(2, rd); chk("R2 X pointer full", rd, DEPTH);
        bus_read(3, rd); chk("R2 Y pointer full", rd, DEPTH);
        // R4 saturation
        bus_write(2, 16'h1111, 2'b10);
        bus_read(2, rd); chk("R4 pointer saturated", rd, DEPTH);
        bus_write(0, 0, 2'b10);
        // R3 write after update cleared
        bus_write(2, 16'h2222, 2'b10);
        bus_write(3, 16'h2222, 2'b10);
        bus_read(3, rd); chk("R3 Y pointer held", rd, DEPTH);

        // Playback sweep: R5 R6 R7 R8 R9
        for (int li = 0; li < 4; li++) begin
            for (int si = 0; si < 3; si++) begin
                for (int rm = 0; rm < 2; rm++) begin
                    int l = lens[li];
                    int s = spds[si];
                    int ncyc = 2 * (s + 1) * ((l < 1) ? 1 : l) + 4;
                    bus_write(1, s, 2'b10);
                    bus_write(0, 1 + (rm << 2) + (l << (DW - AW)), 2'b10);
                    for (int t = 0; t < ncyc; t++) begin
                        @(posedge clk); @(negedge clk);
                        if (rm == 1) begin
                            chk("R8 ramp x", int'(x_out), model(t, l, s, 1'b1, 1'b0));
                            chk("R8 ramp y", int'(y_out), model(t, l, s, 1'b1, 1'b1));
                        end else begin
                            chk("R5 R6 R7 hold x", int'(x_out), model(t, l, s, 1'b0, 1'b0));
                            chk("R5 R6 R7 hold y", int'(y_out), model(t, l, s, 1'b0, 1'b1));
                        end
                    end
                    bus_write(0, 0, 2'b10);
                    @(posedge clk); @(negedge clk);
                    chk("R9 x zero after stop", int'(x_out), 0);
                    chk("R9 y zero after stop", int'(y_out), 0);
                end
            end
        end

        // R10 debug circle, with the pattern running underneath
        bus_write(1, 0, 2'b10);
        bus_write(0, 1 + (5 << (DW - AW)), 2'b10);
        circle_sel = 1'b1;
        begin
            int cx = AMP;
            int cy = 0;
            for (int j = 0; j < 300; j++) begin
                @(posedge clk); @(negedge clk);
                chk("R10 circle x", int'(x_out), cx);
                chk("R10 circle y", int'(y_out), cy);
                cx = cx - (cy >>> SH);
                cy = cy + (cx >>> SH);
            end
        end
        bus_write(0, 0, 2'b10);
        circle_sel = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R9 zero after circle", int'(x_out), 0);

        // R2 rearm clears pointers
        bus_write(0, 2, 2'b10);
        bus_read(2, rd); chk("R2 rearm X pointer", rd, 0);
        bus_write(2, 100, 2'b10);
        bus_write(2, 200, 2'b10);
        bus_read(2, rd); chk("R2 X count after rearm", rd, 2);
        bus_read(3, rd); chk("R2 Y pointer after rearm", rd, 0);
        bus_write(0, 0, 2'b10);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule